// File: doc/BRIEF.md
# SPI Status Register Write Controller

This block is the slave-side command logic of a serial-flash-style SPI target. It handles a 16-bit status register held as two bytes. It also handles the two prefix commands that arm a status write and the two commands that read the bytes back. The SPI pins (`sclk`, `cs_n`, `mosi`) are brought into the system clock domain through a synchronizer of configurable depth. Every SPI event is then handled as a single-cycle edge pulse. Input data is taken on rising SCLK while chip select is low, most significant bit first. Read data is driven on falling SCLK.

A status write is accepted only when it directly follows one of two prefix commands. After the write-enable prefix, the write starts a self-timed non-volatile cycle. During that cycle a BUSY flag is set for a parameterized number of clocks, and at its end the write-enable latch is cleared. After the volatile-enable prefix, the new bits are applied at once and BUSY stays low. The write is committed only if chip select rises right after exactly 8 or exactly 16 data bits. A short 8-bit write also clears the two control bits held in the second byte.

The command sequencer has five states:
- IDLE waits for chip select to fall, which is the *select* transition into OPCODE.
- OPCODE gathers eight bits. On the eighth rising edge it takes the *decode* transition to one of three states:
  - WDATA for the write opcode;
  - RDATA for either read opcode;
  - SKIP for anything else.
- From every state, a rising chip select is the *deselect* transition back to IDLE. On leaving WDATA, the deselect transition also presents the write for commit.

Top module: `sreg_spi_ctrl`

## Requirements
- R1: After reset every status bit reads 0 through both read commands.
- R2: A status write (opcode 01h) changes the register only if chip select rises after exactly 8 or exactly 16 data bits. Any other count, including 0 and 17, leaves both bytes unchanged.
- R3: An accepted 8-bit write loads byte 1 and forces byte 2 bit 1 (QE) and bit 6 (CMP) to 0, leaving the other byte 2 bits as they were. An accepted 16-bit write loads byte 1 from the first data byte and byte 2 from the second.
- R4: Opcode 06h then 01h makes the new bits visible and raises BUSY (byte 1 bit 0) at chip-select rise. BUSY holds for NV_CYCLES clocks and then returns to 0.
- R5: Read-status commands are accepted and answered while BUSY is 1, with BUSY reading 1.
- R6: Opcode 06h sets WEL (byte 1 bit 1) when not busy. The end of the non-volatile cycle clears WEL.
- R7: Opcode 50h then 01h applies the new bits immediately. BUSY stays 0 and WEL is unchanged.
- R8: Opcode 01h is ignored unless the command just before it was 06h or 50h. Any other opcode in between (a read, or an unknown code) cancels the prefix.
- R9: While BUSY is 1, 06h and 50h have no effect, so a following 01h is ignored.
- R10: Opcode 05h returns byte 1 and opcode 35h returns byte 2, MSB first, changed on falling SCLK. The byte repeats while clocks continue. Byte 1 bits 1:0 are never written from data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host, 0 when not reading |

## Verification
The bench builds the block with two synchronizer stages and NV_CYCLES set to 1500. This cycle length is long enough for the bench to poll BUSY several times and to issue a complete blocked prefix-plus-write while the cycle is still running. It is also short enough to wait out the cycle and observe BUSY and WEL fall. A volatile write is swept over every data-bit count from 0 to 17, each count with a different data word. Each write is read back through both read commands, so all commit and discard lengths, and the 8-bit clearing of QE and CMP, are checked against an arithmetic model.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_VOLEN = 8'h50;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_RDSR1 = 8'h05;
    localparam logic [7:0] OP_RDSR2 = 8'h35;

    localparam int QE_BIT  = 1;
    localparam int CMP_BIT = 6;
    localparam int CNT_W   = 5;
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(8);
    localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(16);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } fsm_state_e;

    typedef enum logic [1:0] {
        PFX_NONE,
        PFX_NV,
        PFX_VOL
    } wr_prefix_e;
endpackage

// File: rtl/sreg_spi_sync.sv
module sreg_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic mosi_s
);
    // bit order: {sclk, cs_n, mosi}
    localparam logic [2:0] REST_LVL = 3'b010;

    logic [2:0] raw;
    logic [2:0] synced;
    logic [2:0] prev;

    assign raw = {sclk_in, cs_n_in, mosi_in};

    generate
        if (STAGES > 1) begin : g_chain
            logic [STAGES-1:0][2:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{REST_LVL}};
                else        chain <= {chain[STAGES-2:0], raw};
            end
            assign synced = chain[STAGES-1];
        end else begin : g_single
            logic [2:0] one;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) one <= REST_LVL;
                else        one <= raw;
            end
            assign synced = one;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= REST_LVL;
        else        prev <= synced;
    end

    assign sclk_rise = synced[2] & ~prev[2];
    assign sclk_fall = ~synced[2] & prev[2];
    assign cs_rise   = synced[1] & ~prev[1];
    assign cs_fall   = ~synced[1] & prev[1];
    assign mosi_s    = synced[0];
endmodule

// File: rtl/sreg_cmd_fsm.sv
module sreg_cmd_fsm
    import sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic             mosi_s,
    input  logic [7:0]       rd_byte1,
    input  logic [7:0]       rd_byte2,
    output logic             op_valid,
    output logic [7:0]       op_code,
    output logic             wr_done,
    output logic [CNT_W-1:0] wr_bits,
    output logic [15:0]      wr_data,
    output logic             miso
);
    fsm_state_e       state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [15:0]      shreg;
    logic [7:0]       byte_now;
    logic [2:0]       rd_idx;
    logic             rd_sel;
    logic [7:0]       rd_byte;

    assign byte_now = {shreg[6:0], mosi_s};
    assign rd_byte  = rd_sel ? rd_byte2 : rd_byte1;
    assign wr_bits  = cnt;
    assign wr_data  = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: select, decode, deselect
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cs_fall) nxt = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (cs_rise) begin
                    nxt = ST_IDLE;
                end else if (sclk_rise && cnt == CNT_W'(7)) begin
                    if (byte_now == OP_WRSR)
                        nxt = ST_WDATA;
                    else if (byte_now == OP_RDSR1 || byte_now == OP_RDSR2)
                        nxt = ST_RDATA;
                    else
                        nxt = ST_SKIP;
                end
            end
            ST_WDATA, ST_RDATA, ST_SKIP: begin
                if (cs_rise) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            shreg    <= '0;
            op_valid <= 1'b0;
            op_code  <= '0;
            wr_done  <= 1'b0;
            rd_idx   <= 3'd7;
            rd_sel   <= 1'b0;
            miso     <= 1'b0;
        end else begin
            op_valid <= 1'b0;
            wr_done  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    miso <= 1'b0;
                    if (cs_fall) cnt <= '0;
                end
                ST_OPCODE: begin
                    if (sclk_rise && !cs_rise) begin
                        shreg <= {shreg[14:0], mosi_s};
                        if (cnt == CNT_W'(7)) begin
                            cnt      <= '0;
                            op_valid <= 1'b1;
                            op_code  <= byte_now;
                            rd_sel   <= (byte_now == OP_RDSR2);
                            rd_idx   <= 3'd7;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (cs_rise) begin
                        wr_done <= 1'b1;
                    end else if (sclk_rise) begin
                        shreg <= {shreg[14:0], mosi_s};
                        if (cnt != '1) cnt <= cnt + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (cs_rise) begin
                        miso <= 1'b0;
                    end else if (sclk_fall) begin
                        miso   <= rd_byte[rd_idx];
                        rd_idx <= rd_idx - 1'b1;
                    end
                end
                ST_SKIP: begin
                    miso <= 1'b0;
                end
                default: miso <= 1'b0;
            endcase
        end
    end

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> state == ST_IDLE); // R2
    AST_DECODE_FROM_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(state) == ST_OPCODE); // R10
    AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !miso); // R10
endmodule

// File: rtl/sreg_status.sv
module sreg_status
    import sreg_pkg::*;
#(
    parameter int NV_CYCLES = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [7:0]       op_code,
    input  logic             wr_done,
    input  logic [CNT_W-1:0] wr_bits,
    input  logic [15:0]      wr_data,
    output logic [7:0]       sr1,
    output logic [7:0]       sr2
);
    localparam int TW = (NV_CYCLES > 1) ? $clog2(NV_CYCLES) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(NV_CYCLES - 1);
    localparam logic [7:0] SHORT_MASK = ~((8'h1 << QE_BIT) | (8'h1 << CMP_BIT));

    logic [5:0]    sr1_hi;
    logic [7:0]    sr2_q;
    logic          wel, busy;
    logic [TW-1:0] timer;
    wr_prefix_e    prefix, wmode;
    logic          len_ok, len8;
    logic          unused_rd_only;

    assign len8   = (wr_bits == LEN_SHORT);
    assign len_ok = len8 || (wr_bits == LEN_FULL);
    assign sr1    = {sr1_hi, wel, busy};
    assign sr2    = sr2_q;
    assign unused_rd_only = ^wr_data[9:8];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr1_hi <= '0;
            sr2_q  <= '0;
            wel    <= 1'b0;
            busy   <= 1'b0;
            timer  <= '0;
            prefix <= PFX_NONE;
            wmode  <= PFX_NONE;
        end else begin
            if (busy) begin
                if (timer == '0) begin
                    busy <= 1'b0;
                    wel  <= 1'b0;
                end else begin
                    timer <= timer - 1'b1;
                end
            end
            if (op_valid) begin
                unique case (op_code)
                    OP_WREN: begin
                        if (!busy) begin
                            wel    <= 1'b1;
                            prefix <= PFX_NV;
                        end else begin
                            prefix <= PFX_NONE;
                        end
                    end
                    OP_VOLEN: prefix <= busy ? PFX_NONE : PFX_VOL;
                    OP_WRSR: begin
                        wmode  <= busy ? PFX_NONE : prefix;
                        prefix <= PFX_NONE;
                    end
                    default: prefix <= PFX_NONE;
                endcase
            end
            if (wr_done) begin
                wmode <= PFX_NONE;
                if (wmode != PFX_NONE && len_ok) begin
                    if (len8) begin
                        sr1_hi <= wr_data[7:2];
                        sr2_q  <= sr2_q & SHORT_MASK;
                    end else begin
                        sr1_hi <= wr_data[15:10];
                        sr2_q  <= wr_data[7:0];
                    end
                    if (wmode == PFX_NV) begin
                        busy  <= 1'b1;
                        timer <= T_LAST;
                    end
                end
            end
        end
    end

    AST_NV_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wmode == PFX_NV && len_ok) |=> busy); // R4
    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> timer <= T_LAST); // R4
    AST_WEL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel); // R6
    AST_VOL_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wmode == PFX_VOL) |=> !busy); // R7
    AST_SHORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wmode != PFX_NONE && len8) |=> (!sr2_q[QE_BIT] && !sr2_q[CMP_BIT])); // R3
    AST_BAD_LEN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !len_ok) |=> $stable({sr1_hi, sr2_q})); // R2
    AST_BUSY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && op_code == OP_WRSR) |=> wmode == PFX_NONE); // R9
endmodule

// File: rtl/sreg_spi_ctrl.sv
module sreg_spi_ctrl
    import sreg_pkg::*;
#(
    parameter int NV_CYCLES   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    logic             sclk_rise, sclk_fall, cs_rise, cs_fall, mosi_s;
    logic             op_valid, wr_done;
    logic [7:0]       op_code;
    logic [CNT_W-1:0] wr_bits;
    logic [15:0]      wr_data;
    logic [7:0]       sr1, sr2;

    sreg_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk),
        .cs_n_in   (cs_n),
        .mosi_in   (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .mosi_s    (mosi_s)
    );

    sreg_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise),
        .cs_fall   (cs_fall),
        .mosi_s    (mosi_s),
        .rd_byte1  (sr1),
        .rd_byte2  (sr2),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .wr_done   (wr_done),
        .wr_bits   (wr_bits),
        .wr_data   (wr_data),
        .miso      (miso)
    );

    sreg_status #(.NV_CYCLES(NV_CYCLES)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .wr_done  (wr_done),
        .wr_bits  (wr_bits),
        .wr_data  (wr_data),
        .sr1      (sr1),
        .sr2      (sr2)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $rose(rst_n) |-> (sr1 == 8'h00 && sr2 == 8'h00)); // R1
endmodule

// File: tb/sreg_spi_ctrl_test.sv
module sreg_spi_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NV         = 1500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [5:0] m_hi;
    logic [7:0] m_sr2;
    logic       m_wel;

    always #(CLK_PERIOD/2) clk = ~clk;

    sreg_spi_ctrl #(.NV_CYCLES(NV), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b, output logic r);
        mosi = b;
        repeat (HALF) @(negedge clk);
        r = miso;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xact(input logic [7:0] op, input int nb, input logic [15:0] d,
                        input int nrd, output logic [15:0] rx);
        logic r;
        logic [16:0] dd;
        dd = {d, 1'b0};
        rx = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 7; i >= 0; i--) shift_bit(op[i], r);
        for (int i = 0; i < nb; i++) shift_bit(dd[16-i], r);
        for (int i = 0; i < nrd*8; i++) begin
            shift_bit(1'b0, r);
            rx = {rx[14:0], r};
        end
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3*HALF) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [15:0] rx;
        xact(op, 0, 16'h0, 0, rx);
    endtask

    task automatic read_both(output logic [7:0] s1, output logic [7:0] s2);
        logic [15:0] rx;
        xact(8'h05, 0, 16'h0, 1, rx); s1 = rx[7:0];
        xact(8'h35, 0, 16'h0, 1, rx); s2 = rx[7:0];
    endtask

    function automatic logic [7:0] exp1();
        return {m_hi, m_wel, 1'b0};
    endfunction

    task automatic model_write(input int nb, input logic [15:0] d);
        if (nb == 8) begin
            m_hi  = d[15:10];
            m_sr2 = m_sr2 & 8'hBD;
        end else if (nb == 16) begin
            m_hi  = d[15:10];
            m_sr2 = d[7:0];
        end
    endtask

    task automatic wait_idle(output int polls);
        logic [15:0] rx;
        polls = 0;
        do begin
            xact(8'h05, 0, 16'h0, 1, rx);
            polls++;
        end while (rx[0] && polls < 40);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] s1, s2;
        logic [15:0] rx, d;
        int polls;
        m_hi = '0; m_sr2 = '0; m_wel = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state; R10 byte repeats
        xact(8'h05, 0, 16'h0, 2, rx);
        chk(rx == 16'h0000, "R1 byte1 reset", rx, 16'h0000);
        xact(8'h35, 0, 16'h0, 2, rx);
        chk(rx == 16'h0000, "R1 byte2 reset", rx, 16'h0000);

        // R8 write without prefix
        xact(8'h01, 16, 16'hFFFF, 0, rx);
        read_both(s1, s2);
        chk({s1, s2} == 16'h0000, "R8 no prefix", {s1, s2}, 16'h0000);
        // R8 read between volatile prefix and write
        cmd(8'h50);
        xact(8'h05, 0, 16'h0, 1, rx);
        xact(8'h01, 16, 16'hFFFF, 0, rx);
        read_both(s1, s2);
        chk({s1, s2} == 16'h0000, "R8 read cancels", {s1, s2}, 16'h0000);
        // R8 unknown opcode between; R6 WEL set
        cmd(8'h06);
        cmd(8'hAB);
        xact(8'h01, 16, 16'hFFFF, 0, rx);
        m_wel = 1'b1;
        read_both(s1, s2);
        chk({s1, s2} == {exp1(), m_sr2}, "R8 R6 unknown cancels, WEL set", {s1, s2}, {exp1(), m_sr2});

        // R2 R3 R7 sweep of data-bit counts
        for (int nb = 0; nb <= 17; nb++) begin
            d = 16'hFFFF ^ (16'(nb) * 16'h1357);
            cmd(8'h50);
            xact(8'h01, nb, d, 0, rx);
            model_write(nb, d);
            read_both(s1, s2);
            chk({s1, s2} == {exp1(), m_sr2}, $sformatf("R2 R3 R7 vol len %0d", nb),
                {s1, s2}, {exp1(), m_sr2});
        end

        // R10 readback patterns, byte1 low bits not writable; R7 busy stays 0
        for (int p = 0; p < 8; p++) begin
            d = {8'(8'h03 | (8'(p) << 5) | 8'(p * 4)), 8'(8'hA5 ^ (p * 8'h1D))};
            cmd(8'h50);
            xact(8'h01, 16, d, 0, rx);
            model_write(16, d);
            xact(8'h05, 0, 16'h0, 2, rx);
            chk(rx == {exp1(), exp1()}, "R10 R7 byte1 repeat", rx, {exp1(), exp1()});
            xact(8'h35, 0, 16'h0, 2, rx);
            chk(rx == {m_sr2, m_sr2}, "R10 byte2 repeat", rx, {m_sr2, m_sr2});
        end

        // R4 R5 non-volatile 16-bit write
        cmd(8'h06);
        xact(8'h01, 16, 16'hFC5A, 0, rx);
        model_write(16, 16'hFC5A);
        xact(8'h05, 0, 16'h0, 1, rx);
        chk(rx[7:0] == {m_hi, 2'b11}, "R5 R4 busy polled", rx, {8'h0, m_hi, 2'b11});
        xact(8'h35, 0, 16'h0, 1, rx);
        chk(rx[7:0] == m_sr2, "R4 new bits during busy", rx, {8'h0, m_sr2});
        // R9 write attempts during busy
        cmd(8'h50);
        xact(8'h01, 16, 16'h0000, 0, rx);
        cmd(8'h06);
        xact(8'h01, 8, 16'h0000, 0, rx);
        wait_idle(polls);
        m_wel = 1'b0;
        chk(polls > 1 && polls < 40, "R4 busy ends", 16'(polls), 16'd2);
        read_both(s1, s2);
        chk({s1, s2} == {exp1(), m_sr2}, "R6 R9 after cycle", {s1, s2}, {exp1(), m_sr2});

        // R3 R6 non-volatile 8-bit write
        cmd(8'h06);
        xact(8'h05, 0, 16'h0, 1, rx);
        chk(rx[1] == 1'b1, "R6 WEL after 06h", rx, 16'h0002);
        cmd(8'h06);
        xact(8'h01, 8, 16'h1400, 0, rx);
        model_write(8, 16'h1400);
        wait_idle(polls);
        read_both(s1, s2);
        chk({s1, s2} == {exp1(), m_sr2}, "R3 R6 short nv write", {s1, s2}, {exp1(), m_sr2});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule